// File: doc/BRIEF.md
# Countdown Timer with Maskable Interrupt

This block is a bus-attached countdown timer. Software writes a divisor, then issues control words that load the divisor into the counter, start it or stop it, and choose which tick-enable input drives the count. The counter steps down by one on each selected tick while it runs. When a step finds the counter at one or zero, the timer expires: the counter reloads from the value latched at the last load and bit 0 of a raw event register is set, so the timer repeats for as long as it runs.

Divisors above 2048 do not fit the counter's step rate directly. At load time such a divisor is divided by 2048, and a prescaler then lets only every 2048th selected tick reach the counter. The interrupt output is a level: the OR of raw events ANDed with a mask register. Software clears events through a write-one-to-clear acknowledge register. The bus is a plain single-cycle interface. Writes take effect on the clock edge and reads are combinational from the address.

Top module: `cdt_timer`

## Requirements
- R1: After reset every register reads zero, the timer is stopped and `irq_o` is low.
- R2: Byte offsets: 0x00 divisor (read/write), 0x04 current count (read-only), 0x08 control (read/write, reads the last accepted word), 0x48 mask (read/write), 0x4C acknowledge (write-only, reads 0), 0x50 raw events (read-only), 0x54 masked events (read-only). Every other offset, including 0x10/0x14/0x18, reads zero and ignores writes.
- R3: Control bits [1:0] give the operation: 0 loads the counter, 1 stops, 2 runs. Bits [31:2] give the source: 0 means no ticks, 1 means `ext_tick`, and 4+i means `src_tick[i]` for i = 0..3.
- R4: A control write whose operation is 3, or whose source field is not 0, 1 or 4..7, changes no state and leaves the control readback as it was.
- R5: While running, each selected tick (after prescaling) steps the count down by one. A step with the count at 1 or 0 reloads the latched load value and sets raw bit 0, so the expiry repeats periodically.
- R6: A load with divisor above 2048 sets the count to divisor/2048 (truncated) and makes the counter step once per 2048 selected ticks. A divisor of 2048 or less is loaded as is and steps on every tick.
- R7: `irq_o` equals the OR of (raw AND mask) and follows mask writes on the next cycle. The masked register reads raw AND mask.
- R8: Writing the acknowledge register clears each raw bit written as 1. An expiry in the same cycle wins and leaves bit 0 set.
- R9: While stopped, ticks do not change the count.
- R10: Tick inputs other than the selected source have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ext_tick | input | 1 | External tick enable (source 1) |
| src_tick | input | NUM_SRC | Internal tick enables (sources 4..7) |
| irq_o | output | 1 | Level interrupt, OR of raw AND mask |

## Verification
Two cases are hard to reach. The first is an acknowledge write that lands in the same cycle as an expiry. The bench steps the counter down to one, then drives the acknowledge write and the final selected tick on the same falling edge, so both reach one rising edge together. The second is the prescaled path, which needs thousands of ticks. The bench holds a source enable high and counts the ticks exactly to the 2047th and 2048th, which shows both that the prescaler holds the count and that the step arrives on the right tick.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned SEL_W   = 8;

    localparam logic [7:0] A_DIV    = 8'h00;
    localparam logic [7:0] A_COUNT  = 8'h04;
    localparam logic [7:0] A_CTRL   = 8'h08;
    localparam logic [7:0] A_MASK   = 8'h48;
    localparam logic [7:0] A_ACK    = 8'h4C;
    localparam logic [7:0] A_RAW    = 8'h50;
    localparam logic [7:0] A_MASKED = 8'h54;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_STOP = 2'd1,
        OP_RUN  = 2'd2,
        OP_BAD  = 2'd3
    } op_e;

    typedef struct packed {
        logic [DATA_W-1:0] div;
        logic [DATA_W-1:0] count;
        logic [DATA_W-1:0] reload;
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] raw;
        logic [SEL_W-1:0]  sel;
        logic              run;
        logic              pre;
    } state_t;
endpackage

// File: rtl/cdt_tick_sel.sv
module cdt_tick_sel #(
    parameter int unsigned NUM_SRC = 4,
    parameter int unsigned SEL_W   = 8
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic               ext_tick,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic               tick
);
    localparam int unsigned BASE = 4;

    logic [NUM_SRC-1:0] hit;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign hit[i] = (sel == SEL_W'(BASE + i)) && src_tick[i];
    end

    assign tick = (|hit) || ((sel == SEL_W'(1)) && ext_tick);
endmodule

// File: rtl/cdt_prescale.sv
module cdt_prescale #(
    parameter int unsigned LOG2 = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic bypass,
    output logic step
);
    logic [LOG2-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (en && !bypass) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign step = en && (bypass || (&cnt_q));
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
    import cdt_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned NUM_SRC  = 4,
    parameter int unsigned PRE_LOG2 = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               ext_tick,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic               irq_o
);
    localparam logic [DATA_W-1:0] PRE_LEN  = DATA_W'(1) << PRE_LOG2;
    localparam int unsigned       FIELD_W  = DATA_W - 2;
    localparam int unsigned       SRC_BASE = 4;

    state_t s_d, s_q;

    logic [7:0]         addr8;
    logic               ctrl_wr;
    op_e                op;
    logic [FIELD_W-1:0] sel_field;
    logic               sel_ok;
    logic               ctrl_ok;
    logic               big_div;
    logic               tick;
    logic               step;
    logic               expire;
    logic               pre_clr;

    assign addr8     = 8'(bus_addr);
    assign ctrl_wr   = bus_we && (addr8 == A_CTRL);
    assign op        = op_e'(bus_wdata[1:0]);
    assign sel_field = bus_wdata[DATA_W-1:2];
    assign sel_ok    = (sel_field < FIELD_W'(2)) ||
                       ((sel_field >= FIELD_W'(SRC_BASE)) &&
                        (sel_field <  FIELD_W'(SRC_BASE + NUM_SRC)));
    assign ctrl_ok   = ctrl_wr && (op != OP_BAD) && sel_ok;
    assign big_div   = s_q.div > PRE_LEN;
    assign pre_clr   = ctrl_ok && (op == OP_LOAD);
    assign expire    = s_q.run && step && (s_q.count <= DATA_W'(1));

    cdt_tick_sel #(
        .NUM_SRC (NUM_SRC),
        .SEL_W   (SEL_W)
    ) u_tick_sel (
        .sel      (s_q.sel),
        .ext_tick (ext_tick),
        .src_tick (src_tick),
        .tick     (tick)
    );

    cdt_prescale #(
        .LOG2 (PRE_LOG2)
    ) u_prescale (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (pre_clr),
        .en     (s_q.run && tick),
        .bypass (!s_q.pre),
        .step   (step)
    );

    always_comb begin
        s_d = s_q;

        if (s_q.run && step) begin
            if (expire) s_d.count = s_q.reload;
            else        s_d.count = s_q.count - 1'b1;
        end

        if (bus_we) begin
            unique case (addr8)
                A_DIV:  s_d.div  = bus_wdata;
                A_MASK: s_d.mask = bus_wdata;
                A_ACK:  s_d.raw  = s_q.raw & ~bus_wdata;
                default: ;
            endcase
        end

        if (ctrl_ok) begin
            s_d.ctrl = bus_wdata;
            s_d.sel  = SEL_W'(sel_field);
            unique case (op)
                OP_LOAD: begin
                    s_d.pre    = big_div;
                    s_d.reload = big_div ? (s_q.div >> PRE_LOG2) : s_q.div;
                    s_d.count  = big_div ? (s_q.div >> PRE_LOG2) : s_q.div;
                end
                OP_STOP: s_d.run = 1'b0;
                OP_RUN:  s_d.run = 1'b1;
                default: ;
            endcase
        end

        if (expire) s_d.raw[0] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        unique case (addr8)
            A_DIV:    bus_rdata = s_q.div;
            A_COUNT:  bus_rdata = s_q.count;
            A_CTRL:   bus_rdata = s_q.ctrl;
            A_MASK:   bus_rdata = s_q.mask;
            A_RAW:    bus_rdata = s_q.raw;
            A_MASKED: bus_rdata = s_q.raw & s_q.mask;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_o = |(s_q.raw & s_q.mask);
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk
    import cdt_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              irq_o,
    input logic              step,
    input state_t            st
);
    logic [7:0] a8;
    assign a8 = 8'(bus_addr);

    a_r7_mask_off_quiets: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && a8 == A_MASK && !bus_wdata[0]) |=> !irq_o);

    a_r8_ack_clears_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && a8 == A_ACK && bus_wdata[0] && !(st.run && step && st.count <= 32'd1))
        |=> !st.raw[0]);

    a_r5_expiry_sets_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (st.run && step && st.count <= 32'd1) |=> st.raw[0]);

    a_r9_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!st.run && !(bus_we && a8 == A_CTRL)) |=> $stable(st.count));

    a_r4_bad_op_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && a8 == A_CTRL && bus_wdata[1:0] == 2'b11)
        |=> ($stable(st.ctrl) && $stable(st.run)));
endmodule

bind cdt_timer cdt_timer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_o     (irq_o),
    .step      (step),
    .st        (s_q)
);

// File: tb/cdt_timer_bench.sv
module cdt_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ext_tick = 1'b0;
    logic [3:0]  src_tick = '0;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    cdt_timer u_cdt_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_tick  (ext_tick),
        .src_tick  (src_tick),
        .irq_o     (irq_o)
    );

    // {we, addr, data}: data is write data when we=1, expected read otherwise
    localparam int NVEC = 16;
    localparam logic [40:0] VEC [NVEC] = '{
        {1'b0, 8'h00, 32'h0},   // R1 divisor at reset
        {1'b1, 8'h00, 32'd5},
        {1'b0, 8'h00, 32'd5},   // R2 divisor readback
        {1'b1, 8'h48, 32'd1},
        {1'b0, 8'h48, 32'd1},   // R2 mask readback
        {1'b1, 8'h10, 32'hAA},
        {1'b0, 8'h10, 32'h0},   // R2 reserved offset
        {1'b0, 8'h04, 32'h0},   // R2 count before load
        {1'b1, 8'h08, 32'h10},  // load, source 4
        {1'b0, 8'h04, 32'd5},   // R3 load copies divisor
        {1'b0, 8'h08, 32'h10},  // R2 control readback
        {1'b1, 8'h08, 32'h13},  // op 3
        {1'b0, 8'h08, 32'h10},  // R4 ignored
        {1'b1, 8'h08, 32'h08},  // source 2
        {1'b0, 8'h08, 32'h10},  // R4 ignored
        {1'b0, 8'h50, 32'h0}    // R2 raw clear
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic ticks(input logic [3:0] m, input logic e, input int n);
        for (int i = 0; i < n; i++) begin
            src_tick = m; ext_tick = e;
            @(negedge clk);
        end
        src_tick = '0; ext_tick = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq at reset", {31'b0, irq_o}, 32'd0);

        for (int v = 0; v < NVEC; v++) begin
            if (VEC[v][40]) wr(VEC[v][39:32], VEC[v][31:0]);
            else            rdchk("R2 table", VEC[v][39:32], VEC[v][31:0]);
        end

        // R9: stopped, ticks ignored
        @(negedge clk);
        ticks(4'b0001, 1'b0, 3);
        rdchk("R9 stopped count", 8'h04, 32'd5);

        // run on source 4; other inputs ignored (R10)
        wr(8'h08, 32'h12);
        ticks(4'b0010, 1'b0, 2);
        ticks(4'b0000, 1'b1, 2);
        rdchk("R10 unselected ticks", 8'h04, 32'd5);
        ticks(4'b0001, 1'b0, 4);
        rdchk("R5 count after 4", 8'h04, 32'd1);
        chk("R7 irq before expiry", {31'b0, irq_o}, 32'd0);
        ticks(4'b0001, 1'b0, 1);
        rdchk("R5 reload on expiry", 8'h04, 32'd5);
        rdchk("R5 raw set", 8'h50, 32'd1);
        chk("R7 irq on expiry", {31'b0, irq_o}, 32'd1);
        ticks(4'b0001, 1'b0, 5);
        rdchk("R5 periodic reload", 8'h04, 32'd5);

        // R7 mask
        wr(8'h48, 32'd0);
        chk("R7 irq masked off", {31'b0, irq_o}, 32'd0);
        rdchk("R7 masked read off", 8'h54, 32'd0);
        rdchk("R7 raw kept", 8'h50, 32'd1);
        wr(8'h48, 32'd1);
        chk("R7 irq mask on", {31'b0, irq_o}, 32'd1);
        rdchk("R7 masked read on", 8'h54, 32'd1);

        // R8 acknowledge
        wr(8'h4C, 32'd1);
        rdchk("R8 raw cleared", 8'h50, 32'd0);
        chk("R8 irq cleared", {31'b0, irq_o}, 32'd0);
        rdchk("R2 ack reads zero", 8'h4C, 32'd0);

        // R8 ack and expiry together
        ticks(4'b0001, 1'b0, 4);
        rdchk("R5 count before coincide", 8'h04, 32'd1);
        bus_we = 1'b1; bus_addr = 8'h4C; bus_wdata = 32'd1; src_tick = 4'b0001;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; src_tick = '0;
        rdchk("R8 expiry wins", 8'h50, 32'd1);
        chk("R8 irq stays", {31'b0, irq_o}, 32'd1);
        wr(8'h4C, 32'd1);

        // R3 stop
        wr(8'h08, 32'h11);
        ticks(4'b0001, 1'b0, 3);
        rdchk("R3 stop holds", 8'h04, 32'd5);

        // R6 boundary 2048: no prescale
        wr(8'h00, 32'd2048);
        wr(8'h08, 32'h1C);
        rdchk("R6 load 2048", 8'h04, 32'd2048);
        wr(8'h08, 32'h1E);
        ticks(4'b1000, 1'b0, 1);
        rdchk("R6 2048 steps each tick", 8'h04, 32'd2047);
        wr(8'h08, 32'h1D);

        // R6 prescaled: 6244 / 2048 = 3
        wr(8'h00, 32'd6244);
        wr(8'h08, 32'h1C);
        rdchk("R6 prescaled load", 8'h04, 32'd3);
        wr(8'h08, 32'h1E);
        ticks(4'b1000, 1'b0, 2047);
        rdchk("R6 held 2047 ticks", 8'h04, 32'd3);
        ticks(4'b1000, 1'b0, 1);
        rdchk("R6 step at 2048", 8'h04, 32'd2);
        ticks(4'b1000, 1'b0, 4096);
        rdchk("R6 prescaled reload", 8'h04, 32'd3);
        rdchk("R6 prescaled expiry", 8'h50, 32'd1);
        wr(8'h08, 32'h1D);
        wr(8'h4C, 32'd1);

        // R3 external source
        wr(8'h00, 32'd7);
        wr(8'h08, 32'h04);
        wr(8'h08, 32'h06);
        ticks(4'b0000, 1'b1, 2);
        rdchk("R3 external ticks", 8'h04, 32'd5);
        ticks(4'b1111, 1'b0, 2);
        rdchk("R10 internal ignored", 8'h04, 32'd5);

        // R3 source 0: no ticks
        wr(8'h08, 32'h02);
        ticks(4'b1111, 1'b1, 3);
        rdchk("R3 source 0 idle", 8'h04, 32'd5);
        wr(8'h04, 32'd99);
        rdchk("R2 count read-only", 8'h04, 32'd5);

        // R1 reset
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rdchk("R1 divisor", 8'h00, 32'd0);
        rdchk("R1 count", 8'h04, 32'd0);
        rdchk("R1 control", 8'h08, 32'd0);
        rdchk("R1 mask", 8'h48, 32'd0);
        rdchk("R1 raw", 8'h50, 32'd0);
        chk("R1 irq", {31'b0, irq_o}, 32'd0);
        ticks(4'b1111, 1'b1, 2);
        rdchk("R1 stopped after reset", 8'h04, 32'd0);

        finish_run();
    end
endmodule